// File: doc/BRIEF.md
# Shared-Bus Two-Register Sequencer

This block pairs a small datapath with a fixed-schedule controller. The datapath has two registers, A and B, and a single result bus. Five sources can drive that bus: the external operand and the function units f, g, h and p. A start pulse launches a four-step program that evaluates p(f(x), h(x)). Each clock the controller asserts exactly one bus driver and one register load enable, and the final value lands in register B.

The schedule moves the h result into B before A is overwritten with f(x). The reason is that both results are derived from the operand held in A. A one-cycle done pulse follows the last load. A stop input cancels a run at any step without performing another load. The function units are simple combinational stand-ins, each set by a parameter: f adds a constant, g XORs with a mask, h shifts left and p XORs its two operands. Unit g is wired to the bus, but the schedule never selects it.

Top module: `bus_seq_top`

## Requirements
- R1: With `rst` high at a rising clock edge, registers A and B become 0, the controller returns to idle, and `done` is 0.
- R2: While idle, all five drive selects, both load enables and `done` are 0, and `regA` and `regB` hold their values.
- R3: A `start` seen in idle with `stop` low begins the run. In the first step `selX` and `loadA` are 1, and A captures `xIn` at the end of that step.
- R4: Step two asserts `selH` and `loadB`. B captures h(A) = A shifted left by one bit, truncated to 8 bits.
- R5: Step three asserts `selF` and `loadA`. A captures f(A) = A + 1 modulo 256.
- R6: Step four asserts `selP` and `loadB`. B captures p(A, B) = A XOR B.
- R7: In the cycle after step four, `done` is 1 for exactly one cycle and `regB` equals (x+1) XOR (x<<1). The controller is then idle.
- R8: At most one drive select is 1 in any cycle. A load enable is 1 only together with exactly one drive select. `selG` is never 1.
- R9: A `start` pulse that arrives while a run is in progress is ignored. The run continues and gives the same result, and no second run follows it.
- R10: While `stop` is 1, every drive select and load enable is 0. The next cycle is idle and A and B keep their earlier values. When `stop` and `start` are both 1 in idle, the block stays idle.
- R11: When no drive select is 1, `busData` is 0. Otherwise it carries the value of the selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| stop | input | 1 | Cancels a run immediately |
| xIn | input | 8 | External operand x |
| selX | output | 1 | External operand drives the bus |
| selF | output | 1 | Unit f drives the bus |
| selG | output | 1 | Unit g drives the bus |
| selH | output | 1 | Unit h drives the bus |
| selP | output | 1 | Unit p drives the bus |
| loadA | output | 1 | Register A captures the bus |
| loadB | output | 1 | Register B captures the bus |
| done | output | 1 | One-cycle pulse after the final load |
| regA | output | 8 | Contents of register A |
| regB | output | 8 | Contents of register B (result) |
| busData | output | 8 | Value on the shared bus |

## Verification
The data assertions depend on `xIn` holding steady from the cycle in which `selX` is asserted until the following edge. The bench meets this by changing `xIn` only on falling edges and only together with a `start` pulse. The step-ordering properties let `stop` cut a sequence short. They rely on `stop` being a clean level sampled at the edge, so the bench drives `stop` only on falling edges and holds it for whole cycles. `start` may arrive at any time, including in the middle of a run, to exercise R9.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LDX   = 3'd1,
    ST_LDH   = 3'd2,
    ST_LDF   = 3'd3,
    ST_LDP   = 3'd4,
    ST_DONE  = 3'd5
  } seqState_t;

  typedef struct packed {
    logic drvX;
    logic drvF;
    logic drvG;
    logic drvH;
    logic drvP;
    logic ldA;
    logic ldB;
  } ctrlStrobes_t;

  localparam ctrlStrobes_t STROBES_NONE = '0;

endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         stop,
  output ctrlStrobes_t strobes,
  output logic         done
);

  seqState_t stateQ, stateD;
  ctrlStrobes_t stepStrobes;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  // Next state: stop wins over everything, start only counts in idle.
  always_comb begin
    stateD = stateQ;
    if (stop) begin
      stateD = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (start) stateD = ST_LDX;
        ST_LDX:  stateD = ST_LDH;
        ST_LDH:  stateD = ST_LDF;
        ST_LDF:  stateD = ST_LDP;
        ST_LDP:  stateD = ST_DONE;
        ST_DONE: stateD = ST_IDLE;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  // One source and one destination per step; h reaches B before A is reused.
  always_comb begin
    stepStrobes = STROBES_NONE;
    unique case (stateQ)
      ST_LDX: begin stepStrobes.drvX = 1'b1; stepStrobes.ldA = 1'b1; end
      ST_LDH: begin stepStrobes.drvH = 1'b1; stepStrobes.ldB = 1'b1; end
      ST_LDF: begin stepStrobes.drvF = 1'b1; stepStrobes.ldA = 1'b1; end
      ST_LDP: begin stepStrobes.drvP = 1'b1; stepStrobes.ldB = 1'b1; end
      default: stepStrobes = STROBES_NONE;
    endcase
  end

  // A stop in the current cycle suppresses the pending load.
  assign strobes = stop ? STROBES_NONE : stepStrobes;
  assign done    = (stateQ == ST_DONE);

endmodule

// File: rtl/bus_seq_dpath.sv
module bus_seq_dpath
  import bus_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int F_ADD      = 1,
  parameter int H_SHIFT    = 1,
  parameter int G_MASK     = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] xIn,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] busData
);

  localparam int NUM_SRC = 5;
  localparam logic [DATA_W-1:0] F_CONST = DATA_W'(F_ADD);
  localparam logic [DATA_W-1:0] G_CONST = DATA_W'(G_MASK);

  logic [DATA_W-1:0] aQ, bQ;
  logic [DATA_W-1:0] fOut, gOut, hOut, pOut;
  logic [NUM_SRC-1:0] srcSel;
  logic [DATA_W-1:0] srcVal [NUM_SRC];

  // Placeholder function units.
  assign fOut = aQ + F_CONST;
  assign gOut = aQ ^ G_CONST;
  assign hOut = aQ << H_SHIFT;
  assign pOut = aQ ^ bQ;

  assign srcSel    = {strobes.drvP, strobes.drvH, strobes.drvG, strobes.drvF, strobes.drvX};
  assign srcVal[0] = xIn;
  assign srcVal[1] = fOut;
  assign srcVal[2] = gOut;
  assign srcVal[3] = hOut;
  assign srcVal[4] = pOut;

  // AND-OR bus: undriven reads zero, one-hot select passes one source.
  logic [DATA_W-1:0] gated [NUM_SRC];
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      assign gated[gi] = srcVal[gi] & {DATA_W{srcSel[gi]}};
    end
  endgenerate

  always_comb begin
    busData = '0;
    for (int i = 0; i < NUM_SRC; i++) busData = busData | gated[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aQ <= '0;
      bQ <= '0;
    end else begin
      if (strobes.ldA) aQ <= busData;
      if (strobes.ldB) bQ <= busData;
    end
  end

  assign regA = aQ;
  assign regB = bQ;

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import bus_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int F_ADD   = 1,
  parameter int H_SHIFT = 1,
  parameter int G_MASK  = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [DATA_W-1:0] xIn,
  output logic              selX,
  output logic              selF,
  output logic              selG,
  output logic              selH,
  output logic              selP,
  output logic              loadA,
  output logic              loadB,
  output logic              done,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] busData
);

  ctrlStrobes_t strobes;

  bus_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stop    (stop),
    .strobes (strobes),
    .done    (done)
  );

  bus_seq_dpath #(
    .DATA_W  (DATA_W),
    .F_ADD   (F_ADD),
    .H_SHIFT (H_SHIFT),
    .G_MASK  (G_MASK)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .xIn     (xIn),
    .regA    (regA),
    .regB    (regB),
    .busData (busData)
  );

  assign selX  = strobes.drvX;
  assign selF  = strobes.drvF;
  assign selG  = strobes.drvG;
  assign selH  = strobes.drvH;
  assign selP  = strobes.drvP;
  assign loadA = strobes.ldA;
  assign loadB = strobes.ldB;

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int DATA_W  = 8,
  parameter int F_ADD   = 1,
  parameter int H_SHIFT = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              stop,
  input logic [DATA_W-1:0] xIn,
  input logic              selX,
  input logic              selF,
  input logic              selG,
  input logic              selH,
  input logic              selP,
  input logic              loadA,
  input logic              loadB,
  input logic              done,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regB,
  input logic [DATA_W-1:0] busData
);

  logic [4:0] sels;
  assign sels = {selX, selF, selG, selH, selP};

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (regA == '0 && regB == '0 && !done));

  // R8
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sels) <= 1);

  // R8
  load_needs_driver_chk: assert property (@(posedge clk) disable iff (rst)
    (loadA || loadB) |-> $countones(sels) == 1);

  // R8
  g_unused_chk: assert property (@(posedge clk) disable iff (rst) !selG);

  // R11
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sels == '0) |-> busData == '0);

  // R3
  load_x_chk: assert property (@(posedge clk) disable iff (rst)
    (selX && loadA) |=> regA == $past(xIn));

  // R4
  h_follows_x_chk: assert property (@(posedge clk) disable iff (rst)
    selX |=> (selH || stop));

  // R4
  load_h_chk: assert property (@(posedge clk) disable iff (rst)
    (selH && loadB) |=> regB == DATA_W'($past(regA) << H_SHIFT));

  // R5
  f_follows_h_chk: assert property (@(posedge clk) disable iff (rst)
    selH |=> (selF || stop));

  // R5
  load_f_chk: assert property (@(posedge clk) disable iff (rst)
    (selF && loadA) |=> regA == DATA_W'($past(regA) + DATA_W'(F_ADD)));

  // R6
  p_follows_f_chk: assert property (@(posedge clk) disable iff (rst)
    selF |=> (selP || stop));

  // R6
  load_p_chk: assert property (@(posedge clk) disable iff (rst)
    (selP && loadB) |=> regB == ($past(regA) ^ $past(regB)));

  // R7
  done_after_p_chk: assert property (@(posedge clk) disable iff (rst)
    selP |=> done);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stop |-> (sels == '0 && !loadA && !loadB));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> (sels == '0 && !done && $stable(regA) && $stable(regB)));

endmodule

bind bus_seq_top bus_seq_chk #(
  .DATA_W  (DATA_W),
  .F_ADD   (F_ADD),
  .H_SHIFT (H_SHIFT)
) u_chk (.*);

// File: tb/bus_seq_top_bench.sv
module bus_seq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [7:0] X_VEC [NVEC] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};

  logic clk = 1'b0;
  logic rst, start, stop;
  logic [7:0] xIn;
  logic selX, selF, selG, selH, selP, loadA, loadB, done;
  logic [7:0] regA, regB, busData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_seq_top u_bus_seq_top (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .xIn(xIn),
    .selX(selX), .selF(selF), .selG(selG), .selH(selH), .selP(selP),
    .loadA(loadA), .loadB(loadB), .done(done),
    .regA(regA), .regB(regB), .busData(busData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] ctl();
    return {selX, selF, selG, selH, selP, loadA, loadB};
  endfunction

  task automatic stepNeg();
    @(negedge clk);
  endtask

  // Checks one full run from a start pulse; startMid raises start in step two.
  task automatic runVector(input logic [7:0] x, input bit startMid);
    logic [7:0] expH, expF, expP;
    expH = x << 1;
    expF = x + 8'd1;
    expP = expF ^ expH;
    xIn = x; start = 1'b1;
    stepNeg(); start = 1'b0;
    // R3 step one
    chk(ctl() == 7'b1000010, "R3 ctl", ctl(), 7'b1000010);
    chk(busData == x, "R11 bus x", busData, x);
    stepNeg();
    if (startMid) begin start = 1'b1; xIn = ~x; #1; end
    // R4 step two
    chk(regA == x, "R3 regA", regA, x);
    chk(ctl() == 7'b0001001, "R4 ctl", ctl(), 7'b0001001);
    stepNeg(); start = 1'b0;
    chk(regB == expH, "R4 regB", regB, expH);
    // R5 step three (R9: mid-run start must not disturb it)
    chk(ctl() == 7'b0100010, "R5 ctl", ctl(), 7'b0100010);
    stepNeg();
    chk(regA == expF, "R5 regA", regA, expF);
    chk(ctl() == 7'b0000101, "R6 ctl", ctl(), 7'b0000101);
    chk(busData == expP, "R6 bus", busData, expP);
    stepNeg();
    chk(done == 1'b1, "R7 done", done, 1);
    chk(regB == expP, "R7 result", regB, expP);
    chk(ctl() == 7'b0, "R2 ctl in done", ctl(), 0);
    stepNeg();
    chk(done == 1'b0, "R7 done width", done, 0);
    chk(ctl() == 7'b0 && busData == 8'h00, "R11 idle bus", {ctl(), busData}, 0);
    chk(regB == expP, "R2 hold B", regB, expP);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; stop = 1'b0; xIn = 8'h00;
    stepNeg(); stepNeg();
    // R1 reset state
    chk(regA == 0 && regB == 0, "R1 regs", {regA, regB}, 0);
    chk(ctl() == 0 && done == 0, "R1 ctl", {ctl(), done}, 0);
    rst = 1'b0;

    // R2 idle holds with no start
    xIn = 8'h33;
    stepNeg(); stepNeg();
    chk(ctl() == 0 && regA == 0 && busData == 0, "R2 idle", {ctl(), regA}, 0);

    // Vector table
    for (int i = 0; i < NVEC; i++) runVector(X_VEC[i], 1'b0);

    // R9 start while busy ignored, no second run
    runVector(8'h3C, 1'b1);
    chk(ctl() == 0, "R9 no restart", ctl(), 0);
    stepNeg();
    chk(ctl() == 0 && !done, "R9 still idle", {ctl(), done}, 0);

    // R10 stop during step three
    xIn = 8'h21; start = 1'b1;
    stepNeg(); start = 1'b0;
    stepNeg(); stepNeg();
    stop = 1'b1; #1;
    chk(ctl() == 0, "R10 stop gates", ctl(), 0);
    stepNeg(); stop = 1'b0;
    chk(regA == 8'h21, "R10 A kept", regA, 8'h21);
    chk(regB == 8'h42, "R10 B kept", regB, 8'h42);
    chk(ctl() == 0 && !done, "R10 idle", {ctl(), done}, 0);
    stepNeg();
    chk(ctl() == 0 && regA == 8'h21, "R10 stays idle", {ctl(), regA}, 8'h21);

    // R10 stop and start together in idle
    stop = 1'b1; start = 1'b1; xIn = 8'h77;
    stepNeg(); stop = 1'b0; start = 1'b0;
    chk(ctl() == 0 && regA == 8'h21, "R10 stop beats start", {ctl(), regA}, 8'h21);

    // R1 reset mid-run
    xIn = 8'h99; start = 1'b1;
    stepNeg(); start = 1'b0;
    stepNeg();
    rst = 1'b1;
    stepNeg(); rst = 1'b0;
    chk(regA == 0 && regB == 0, "R1 mid-run regs", {regA, regB}, 0);
    chk(ctl() == 0 && !done, "R1 mid-run idle", {ctl(), done}, 0);

    // R8 g never driven over a full run
    runVector(8'hC3, 1'b0);
    chk(selG == 1'b0, "R8 g unused", selG, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule